// File: doc/BRIEF.md
# Dual-Processor Mailbox Exchange Unit

This block joins two processor cores, called side A and side B, so that each can hand 24-bit data words and a small set of signal flags to the other at the same time. Every side sees the same four-register port: a data register, a status register, a flag register and an interrupt-enable register. A write to a side's data register goes straight into the receive FIFO of the opposite side. There is no transmit buffer. A read of the data register takes the oldest word out of the side's own receive FIFO.

Each side also drives four flag bits that the peer can read. When the peer's flags change, a sticky pending bit is set. The receive condition and the flag-change condition can each be enabled to drive the side's interrupt output. Sticky error bits record words dropped on a full peer FIFO and reads of an empty FIFO. All three sticky bits are cleared by writing 1 to them.

Top module: `mbx_exchange`

## Requirements
- R1: A word written at register address 0 of one side enters the other side's receive FIFO. Reads at address 0 on that side return the words in the order they were written. Both directions work in the same cycle without affecting each other.
- R2: Each receive FIFO holds 10 words. The status register at address 1 reports the following, in bits of its own:
  - bit 0: own FIFO not empty
  - bit 1: own FIFO full
  - bit 2: peer FIFO full
  - bits 11:8: own FIFO fill count
- R3: A data write while the peer FIFO is full is discarded, and status bit 3 (overflow) becomes 1 and stays 1. Writing the status register with bit 3 set clears it.
- R4: A data read while the own FIFO is empty returns 0 and leaves the FIFO unchanged. Status bit 4 (underflow) becomes 1 and stays 1. Writing the status register with bit 4 set clears it.
- R5: A write to address 2 sets the side's own outgoing flags from bits 3:0. A read of address 2 returns the own flags in bits 7:4 and the peer's flags in bits 3:0.
- R6: Status bit 5 (flag change pending) is set at the second clock edge after the peer writes a flag value that differs from the old one. The bit stays set until status is written with bit 5 set. If a new change arrives in the same cycle as the clear, the bit stays set.
- R7: Address 3 holds the interrupt enables: bit 0 for receive, bit 1 for flag change. The interrupt output is a level. It is high exactly while the receive enable is set and the own FIFO is non-empty, or while the flag enable is set and the pending bit is set.
- R8: Read data appears on the read-data port one cycle after the read request and holds until the next read. After reset, every register, the FIFOs and the outputs are 0.
- R9: A pop and a push on the same FIFO in the same cycle are both carried out when the FIFO is neither empty nor full. When the FIFO is full at the start of the cycle, the push is dropped even if a pop happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Side A register access request |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 2 | Side A register address |
| a_wdata | input | 24 | Side A write data |
| a_rdata | output | 24 | Side A registered read data |
| a_irq | output | 1 | Side A interrupt level |
| b_req | input | 1 | Side B register access request |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 2 | Side B register address |
| b_wdata | input | 24 | Side B write data |
| b_rdata | output | 24 | Side B registered read data |
| b_irq | output | 1 | Side B interrupt level |

## Verification
The hardest state to reach is a cycle in which one side pops its full FIFO while the peer pushes into it. The push must be dropped and overflow flagged, even though the pop frees a slot before the next edge. A directed sequence fills the FIFO to ten words, then drives both ports in one cycle, then repeats at nine words where both operations must succeed. Random phases biased first toward writes and then toward reads sweep the fill level over its whole range while flag, enable and status-clear writes are mixed in.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W = 24;
    localparam int FLAG_W = 4;
    localparam int DEPTH  = 10;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_STAT = 2'd1,
        REG_FLAG = 2'd2,
        REG_IEN  = 2'd3
    } reg_sel_e;

    // status bit positions
    localparam int ST_NE    = 0;
    localparam int ST_FULL  = 1;
    localparam int ST_PFULL = 2;
    localparam int ST_OVF   = 3;
    localparam int ST_UNF   = 4;
    localparam int ST_PEND  = 5;
    localparam int ST_CNT   = 8;

    // interrupt enable bit positions
    localparam int IE_RX   = 0;
    localparam int IE_FLAG = 1;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int W     = mbx_pkg::DATA_W,
    parameter int DEPTH = mbx_pkg::DEPTH,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [W-1:0]     push_data_i,
    input  logic             pop_i,
    output logic [W-1:0]     head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = push_i && (st_q.cnt != CNT_W'(DEPTH));
        pop_ok  = pop_i && (st_q.cnt != '0);
        if (push_ok) begin
            st_d.mem[st_q.wp] = push_data_i;
            st_d.wp           = ptr_inc(st_q.wp);
        end
        if (pop_ok) begin
            st_d.rp = ptr_inc(st_q.rp);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rp];
    assign count_o = st_q.cnt;
    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == CNT_W'(DEPTH));

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    assert_full_drops_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i) |=> (st_q.cnt == $past(st_q.cnt)));

    assert_push_pop_balance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !full_o && !empty_o) |=> (st_q.cnt == $past(st_q.cnt)));
endmodule

// File: rtl/mbx_port.sv
module mbx_port #(
    parameter int W     = mbx_pkg::DATA_W,
    parameter int FW    = mbx_pkg::FLAG_W,
    parameter int DEPTH = mbx_pkg::DEPTH,
    parameter int AW    = mbx_pkg::ADDR_W,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [W-1:0]     wdata_i,
    output logic [W-1:0]     rdata_o,
    output logic             irq_o,
    input  logic [W-1:0]     rx_head_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic             rx_empty_i,
    input  logic             rx_full_i,
    input  logic             peer_full_i,
    input  logic [FW-1:0]    peer_flags_i,
    output logic [FW-1:0]    flags_o,
    output logic             push_o,
    output logic [W-1:0]     push_data_o,
    output logic             pop_o
);
    import mbx_pkg::*;

    typedef struct packed {
        logic [W-1:0]  rdata;
        logic [FW-1:0] flags;
        logic [FW-1:0] seen;
        logic [1:0]    ien;
        logic          ovf;
        logic          unf;
        logic          pend;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     rd_acc, wr_acc, sel_data;
    logic     flag_moved;
    logic [W-1:0] status_word, flag_word;
    reg_sel_e sel;

    always_comb begin
        sel      = reg_sel_e'(addr_i);
        rd_acc   = req_i && !we_i;
        wr_acc   = req_i && we_i;
        sel_data = (sel == REG_DATA);

        status_word                   = '0;
        status_word[ST_NE]            = !rx_empty_i;
        status_word[ST_FULL]          = rx_full_i;
        status_word[ST_PFULL]         = peer_full_i;
        status_word[ST_OVF]           = st_q.ovf;
        status_word[ST_UNF]           = st_q.unf;
        status_word[ST_PEND]          = st_q.pend;
        status_word[ST_CNT +: CNT_W]  = rx_count_i;

        flag_word              = '0;
        flag_word[FW-1:0]      = peer_flags_i;
        flag_word[2*FW-1:FW]   = st_q.flags;

        flag_moved  = (peer_flags_i != st_q.seen);
        push_o      = wr_acc && sel_data && !peer_full_i;
        push_data_o = wdata_i;
        pop_o       = rd_acc && sel_data && !rx_empty_i;

        st_d      = st_q;
        st_d.seen = peer_flags_i;

        if (wr_acc) begin
            case (sel)
                REG_DATA: if (peer_full_i) st_d.ovf = 1'b1;
                REG_STAT: begin
                    if (wdata_i[ST_OVF])  st_d.ovf  = 1'b0;
                    if (wdata_i[ST_UNF])  st_d.unf  = 1'b0;
                    if (wdata_i[ST_PEND]) st_d.pend = 1'b0;
                end
                REG_FLAG: st_d.flags = wdata_i[FW-1:0];
                REG_IEN:  st_d.ien   = wdata_i[1:0];
                default: ;
            endcase
        end

        if (rd_acc) begin
            case (sel)
                REG_DATA: begin
                    st_d.rdata = rx_empty_i ? '0 : rx_head_i;
                    if (rx_empty_i) st_d.unf = 1'b1;
                end
                REG_STAT: st_d.rdata = status_word;
                REG_FLAG: st_d.rdata = flag_word;
                REG_IEN:  st_d.rdata = W'(st_q.ien);
                default:  st_d.rdata = '0;
            endcase
        end

        if (flag_moved) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
    assign flags_o = st_q.flags;
    assign irq_o   = (st_q.ien[IE_RX] && !rx_empty_i) || (st_q.ien[IE_FLAG] && st_q.pend);

    assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && addr_i == REG_DATA && peer_full_i) |=> st_q.ovf);

    assert_underflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && addr_i == REG_DATA && rx_empty_i) |=> (st_q.unf && st_q.rdata == '0));

    assert_flag_change_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_flags_i != st_q.seen) |=> st_q.pend);

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(rdata_o));
endmodule

// File: rtl/mbx_exchange.sv
module mbx_exchange #(
    parameter int DATA_W = mbx_pkg::DATA_W,
    parameter int FLAG_W = mbx_pkg::FLAG_W,
    parameter int DEPTH  = mbx_pkg::DEPTH,
    parameter int ADDR_W = mbx_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq,
    input  logic              b_req,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SIDES = 2;

    logic              req       [SIDES];
    logic              we        [SIDES];
    logic [ADDR_W-1:0] addr      [SIDES];
    logic [DATA_W-1:0] wdata     [SIDES];
    logic [DATA_W-1:0] rdata     [SIDES];
    logic              irq       [SIDES];
    logic              push      [SIDES];
    logic [DATA_W-1:0] push_data [SIDES];
    logic              pop       [SIDES];
    logic [DATA_W-1:0] head      [SIDES];
    logic [CNT_W-1:0]  cnt       [SIDES];
    logic              empty     [SIDES];
    logic              full      [SIDES];
    logic [FLAG_W-1:0] flags     [SIDES];

    assign req[0]   = a_req;
    assign we[0]    = a_we;
    assign addr[0]  = a_addr;
    assign wdata[0] = a_wdata;
    assign req[1]   = b_req;
    assign we[1]    = b_we;
    assign addr[1]  = b_addr;
    assign wdata[1] = b_wdata;
    assign a_rdata  = rdata[0];
    assign a_irq    = irq[0];
    assign b_rdata  = rdata[1];
    assign b_irq    = irq[1];

    for (genvar i = 0; i < SIDES; i++) begin : g_side
        localparam int P = SIDES - 1 - i;

        // receive FIFO of side i, filled by the peer's port
        mbx_fifo #(.W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_i     (push[P]),
            .push_data_i(push_data[P]),
            .pop_i      (pop[i]),
            .head_o     (head[i]),
            .count_o    (cnt[i]),
            .empty_o    (empty[i]),
            .full_o     (full[i])
        );

        mbx_port #(.W(DATA_W), .FW(FLAG_W), .DEPTH(DEPTH), .AW(ADDR_W), .CNT_W(CNT_W)) u_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_i       (req[i]),
            .we_i        (we[i]),
            .addr_i      (addr[i]),
            .wdata_i     (wdata[i]),
            .rdata_o     (rdata[i]),
            .irq_o       (irq[i]),
            .rx_head_i   (head[i]),
            .rx_count_i  (cnt[i]),
            .rx_empty_i  (empty[i]),
            .rx_full_i   (full[i]),
            .peer_full_i (full[P]),
            .peer_flags_i(flags[P]),
            .flags_o     (flags[i]),
            .push_o      (push[i]),
            .push_data_o (push_data[i]),
            .pop_o       (pop[i])
        );
    end
endmodule

// File: tb/sim_mbx_exchange.sv
module sim_mbx_exchange;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_req, a_we, b_req, b_we;
    logic [1:0]  a_addr, b_addr;
    logic [23:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int checks = 0;
    int errors = 0;

    // pending operation per side (0 = A, 1 = B)
    logic        op_req [2];
    logic        op_we  [2];
    logic [1:0]  op_addr[2];
    logic [23:0] op_wd  [2];

    // reference model
    logic [23:0] mq   [2][DEPTH];
    int          mcnt [2];
    logic [3:0]  mflag[2];
    logic [3:0]  mseen[2];
    logic [1:0]  men  [2];
    logic        movf [2];
    logic        munf [2];
    logic        mpend[2];
    logic [23:0] exp_rd[2];

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_exchange u0 (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    task automatic chk(input string tag, input string what, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [23:0] model_read(input int s, input logic [1:0] a);
        int p = 1 - s;
        logic [23:0] v = '0;
        case (a)
            2'd0: v = (mcnt[s] > 0) ? mq[s][0] : 24'd0;
            2'd1: begin
                v[0] = mcnt[s] > 0;
                v[1] = mcnt[s] == DEPTH;
                v[2] = mcnt[p] == DEPTH;
                v[3] = movf[s];
                v[4] = munf[s];
                v[5] = mpend[s];
                v[11:8] = 4'(mcnt[s]);
            end
            2'd2: v[7:0] = {mflag[s], mflag[p]};
            default: v[1:0] = men[s];
        endcase
        return v;
    endfunction

    function automatic string auto_tag(input logic [1:0] a);
        case (a)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic clear_ops();
        for (int s = 0; s < 2; s++) begin
            op_req[s] = 1'b0; op_we[s] = 1'b0; op_addr[s] = 2'd0; op_wd[s] = '0;
        end
    endtask

    task automatic tick(input string tag);
        int          cpre[2];
        logic [3:0]  fpre[2];
        logic        setp[2];
        string       rtag[2];
        a_req = op_req[0]; a_we = op_we[0]; a_addr = op_addr[0]; a_wdata = op_wd[0];
        b_req = op_req[1]; b_we = op_we[1]; b_addr = op_addr[1]; b_wdata = op_wd[1];
        for (int s = 0; s < 2; s++) begin
            cpre[s] = mcnt[s];
            fpre[s] = mflag[s];
            rtag[s] = "R8";
        end
        for (int s = 0; s < 2; s++) begin
            if (op_req[s] && !op_we[s]) begin
                exp_rd[s] = model_read(s, op_addr[s]);
                rtag[s]   = (tag != "") ? tag : auto_tag(op_addr[s]);
            end
            setp[s]  = fpre[1-s] != mseen[s];
            mseen[s] = fpre[1-s];
        end
        // pops first
        for (int s = 0; s < 2; s++) begin
            if (op_req[s] && !op_we[s] && op_addr[s] == 2'd0) begin
                if (cpre[s] == 0) munf[s] = 1'b1;
                else begin
                    for (int k = 0; k < DEPTH - 1; k++) mq[s][k] = mq[s][k+1];
                    mcnt[s]--;
                end
            end
        end
        // pushes, gated by the fill level at the start of the cycle (R9)
        for (int s = 0; s < 2; s++) begin
            int p = 1 - s;
            if (op_req[s] && op_we[s]) begin
                case (op_addr[s])
                    2'd0: begin
                        if (cpre[p] == DEPTH) movf[s] = 1'b1;
                        else begin
                            mq[p][mcnt[p]] = op_wd[s];
                            mcnt[p]++;
                        end
                    end
                    2'd1: begin
                        if (op_wd[s][3]) movf[s]  = 1'b0;
                        if (op_wd[s][4]) munf[s]  = 1'b0;
                        if (op_wd[s][5]) mpend[s] = 1'b0;
                    end
                    2'd2: mflag[s] = op_wd[s][3:0];
                    default: men[s] = op_wd[s][1:0];
                endcase
            end
            if (setp[s]) mpend[s] = 1'b1;
        end
        @(posedge clk);
        #1;
        chk(rtag[0], "A rdata", a_rdata, exp_rd[0]);
        chk(rtag[1], "B rdata", b_rdata, exp_rd[1]);
        chk("R7", "A irq", {23'd0, a_irq},
            {23'd0, (men[0][0] && mcnt[0] > 0) || (men[0][1] && mpend[0])});
        chk("R7", "B irq", {23'd0, b_irq},
            {23'd0, (men[1][0] && mcnt[1] > 0) || (men[1][1] && mpend[1])});
        clear_ops();
    endtask

    task automatic set_op(input int s, input logic w, input logic [1:0] a, input logic [23:0] d);
        op_req[s] = 1'b1; op_we[s] = w; op_addr[s] = a; op_wd[s] = d;
    endtask

    task automatic rand_op(input int s, input int wr_pct);
        int r = int'($urandom_range(99));
        if (r >= 70) return;
        r = int'($urandom_range(99));
        if (r < 55)      set_op(s, ($urandom_range(99) < wr_pct), 2'd0, 24'($urandom));
        else if (r < 75) set_op(s, $urandom_range(1), 2'd1, {18'd0, 3'($urandom), 3'd0});
        else if (r < 92) set_op(s, $urandom_range(1), 2'd2, 24'($urandom));
        else             set_op(s, $urandom_range(1), 2'd3, 24'($urandom));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 24'd1, 24'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_ops();
        a_req = 0; a_we = 0; a_addr = 0; a_wdata = 0;
        b_req = 0; b_we = 0; b_addr = 0; b_wdata = 0;
        for (int s = 0; s < 2; s++) begin
            mcnt[s] = 0; mflag[s] = 0; mseen[s] = 0; men[s] = 0;
            movf[s] = 0; munf[s] = 0; mpend[s] = 0; exp_rd[s] = 0;
            for (int k = 0; k < DEPTH; k++) mq[s][k] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R8: reset state at the ports
        chk("R8", "reset A rdata", a_rdata, 24'd0);
        chk("R8", "reset B rdata", b_rdata, 24'd0);
        chk("R8", "reset irqs", {22'd0, a_irq, b_irq}, 24'd0);
        set_op(0, 1'b0, 2'd1, 0); tick("R2");

        // R1/R7: enable A receive interrupt, B fills A's FIFO
        set_op(0, 1'b1, 2'd3, 24'd1); tick("");
        for (int k = 0; k < DEPTH; k++) begin
            set_op(1, 1'b1, 2'd0, 24'h100 + 24'(k)); tick("R1");
        end
        set_op(0, 1'b0, 2'd1, 0); tick("R2");
        // R3: eleventh word dropped, overflow on B
        set_op(1, 1'b1, 2'd0, 24'hBAD); tick("R3");
        set_op(1, 1'b0, 2'd1, 0); tick("R3");
        // R9: full at start -> pop happens, push dropped
        set_op(0, 1'b0, 2'd0, 0); set_op(1, 1'b1, 2'd0, 24'hDEAD); tick("R9");
        set_op(0, 1'b0, 2'd1, 0); tick("R9");
        // R9: at nine words both proceed
        set_op(0, 1'b0, 2'd0, 0); set_op(1, 1'b1, 2'd0, 24'hBEEF); tick("R9");
        set_op(0, 1'b0, 2'd1, 0); tick("R9");
        // R3: clear overflow by write-one
        set_op(1, 1'b1, 2'd1, 24'h8); tick("");
        set_op(1, 1'b0, 2'd1, 0); tick("R3");
        // R1: drain, then R4 underflow
        for (int k = 0; k < DEPTH - 1; k++) begin
            set_op(0, 1'b0, 2'd0, 0); tick("R1");
        end
        set_op(0, 1'b0, 2'd0, 0); tick("R4");
        set_op(0, 1'b0, 2'd1, 0); tick("R4");
        set_op(0, 1'b1, 2'd1, 24'h10); tick("");
        set_op(0, 1'b0, 2'd1, 0); tick("R4");
        // R5/R6: flags from A to B
        set_op(1, 1'b1, 2'd3, 24'd2); set_op(0, 1'b1, 2'd2, 24'h5); tick("");
        tick("");
        set_op(1, 1'b0, 2'd1, 0); tick("R6");
        set_op(1, 1'b0, 2'd2, 0); tick("R5");
        // R6: clear coinciding with a new change keeps pending
        set_op(0, 1'b1, 2'd2, 24'hA); tick("");
        set_op(1, 1'b1, 2'd1, 24'h20); tick("");
        set_op(1, 1'b0, 2'd1, 0); tick("R6");
        set_op(1, 1'b1, 2'd1, 24'h20); tick("");
        set_op(1, 1'b0, 2'd1, 0); tick("R6");

        // random phases: write-heavy, balanced, read-heavy
        for (int ph = 0; ph < 3; ph++) begin
            int wp = (ph == 0) ? 85 : (ph == 1) ? 50 : 15;
            for (int n = 0; n < 1500; n++) begin
                rand_op(0, wp);
                rand_op(1, wp);
                tick("");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule